// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a write to a serial memory has been closed by a stop condition, the memory runs an internal programming cycle. While that cycle runs, the memory does not acknowledge its own address. This block sits above a byte-level two-wire bus master and uses that behaviour to detect the end of the cycle, instead of waiting out a fixed worst-case delay. When triggered, it opens the bus with a start condition and sends the device address with the write direction bit. A not-acknowledge means the memory is still busy. The block then waits a parameterised gap and tries again. Before the new start it either issues a stop or goes straight to a repeated start, as chosen at trigger time. The first acknowledge ends the polling and raises `ready`.

On success the block can close the bus with a stop. It can also leave the transaction open, so that the next read or write continues directly after the acknowledged address. A limit on the number of attempts keeps a dead or absent device from hanging the controller. The limit should be sized so that the attempts cover a busy time of about 5 ms. When the limit is reached, the block releases the bus with a stop and raises `timeout_err`.

The byte engine is driven through a request/done handshake. A request stays asserted, with its operation and byte held, until the engine pulses `eng_done`. For a byte send, `eng_ack` is returned together with `eng_done`.

Top module: `ackpoll_ctrl`

## Requirements
- R1: While reset is active and right after it, `ready`, `timeout_err` and `eng_req` are 0.
- R2: A `trig` pulse accepted while idle starts an attempt. The block requests a START (`eng_op`=0), then a SEND (`eng_op`=1) whose `eng_byte` holds `dev_addr` in bits 7:1 and 0 in bit 0.
- R3: A SEND completed with `eng_ack`=0 leads to another attempt. If `nack_rstart`=0 was captured at the trigger, a STOP (`eng_op`=2) is requested before the next START. If `nack_rstart`=1 was captured, no STOP is requested.
- R4: The next START is first requested exactly GAP_CYC+1 cycles after the `eng_done` that ended the previous attempt. That is the STOP's done, or, in repeated-start mode, the not-acknowledged SEND's done.
- R5: On an acknowledged SEND with `hold_bus`=0 captured, one STOP is requested and `ready` rises after its done. With `hold_bus`=1, `ready` rises in the cycle after the acknowledge and no STOP is requested.
- R6: An acknowledge on attempt number MAX_TRIES counts as success: `ready` rises and `timeout_err` stays 0.
- R7: After MAX_TRIES not-acknowledged attempts, exactly one STOP is requested and `timeout_err` rises after its done. No further START follows.
- R8: `ready` and `timeout_err` are never both 1. Each holds until the next accepted trigger, which clears both in the following cycle.
- R9: A `trig` pulse during polling is ignored. The number of STARTs and STOPs and the outcome stay as for an undisturbed run.
- R10: `eng_req`, `eng_op` and `eng_byte` stay stable from the rise of a request until its `eng_done`. No request is made while `ready` or `timeout_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig | input | 1 | Start polling (the write stop has been issued) |
| dev_addr | input | 7 | Device address, held stable during polling |
| hold_bus | input | 1 | Captured at trigger: 1 leaves the bus open after success |
| nack_rstart | input | 1 | Captured at trigger: 1 uses a repeated start after a not-acknowledge |
| eng_req | output | 1 | Request to the byte engine, held until done |
| eng_op | output | 2 | 0 START, 1 SEND, 2 STOP |
| eng_byte | output | 8 | Byte for a SEND request |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_ack | input | 1 | Acknowledge seen for a SEND, valid with `eng_done` |
| ready | output | 1 | Write cycle finished; the next command may proceed |
| timeout_err | output | 1 | No acknowledge within MAX_TRIES attempts |

## Verification
The attempt limit and the acknowledge can meet on the same SEND. On the last allowed attempt, the counter says "final" while the engine reports an acknowledge. The bench provokes this by programming the responder to refuse exactly MAX_TRIES-1 times. It judges that `ready` rises, `timeout_err` stays low and exactly MAX_TRIES STARTs were issued. It contrasts this with MAX_TRIES refusals, which must end in a timeout. A second coincidence is a `trig` that arrives while polling is under way. The bench pulses it mid-run and checks that the start and stop counts match the undisturbed expectation.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;
  localparam int DEV_AW = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_STOP  = 2'd2
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_NSTOP,
    ST_GAP,
    ST_FSTOP,
    ST_ESTOP
  } poll_st_e;
endpackage

// File: rtl/ackpoll_try_cnt.sv
module ackpoll_try_cnt #(
  parameter int MAX_TRIES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int TW = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // current NACK is the final permitted one
  assign last = (cnt_q == TW'(MAX_TRIES - 1));
endmodule

// File: rtl/ackpoll_gap_tmr.sv
module ackpoll_gap_tmr #(
  parameter int GAP_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? GW'(GAP_CYC - 1) : cnt_q - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DEV_AW-1:0] dev_addr,
  input  logic              hold_bus,
  input  logic              nack_rstart,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic              try_last,
  input  logic              gap_expired,
  output logic              try_clr,
  output logic              try_inc,
  output logic              gap_load,
  output logic              gap_run,
  output logic              eng_req,
  output eng_op_e           eng_op,
  output logic [7:0]        eng_byte,
  output logic              ready,
  output logic              timeout_err
);
  poll_st_e          st_q, st_d;
  logic [DEV_AW-1:0] addr_q;
  logic              hold_q, rstart_q;
  logic              cap_en, set_rdy, set_to;
  logic              rdy_q, to_q, rdy_en, to_en;

  always_comb begin
    st_d     = st_q;
    cap_en   = 1'b0;
    try_clr  = 1'b0;
    try_inc  = 1'b0;
    gap_load = 1'b0;
    set_rdy  = 1'b0;
    set_to   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (trig) begin
        st_d    = ST_START;
        cap_en  = 1'b1;
        try_clr = 1'b1;
      end
      ST_START: if (eng_done) st_d = ST_ADDR;
      ST_ADDR: if (eng_done) begin
        if (eng_ack) begin
          if (hold_q) begin
            st_d    = ST_IDLE;
            set_rdy = 1'b1;
          end else begin
            st_d = ST_FSTOP;
          end
        end else begin
          try_inc = 1'b1;
          if (try_last) begin
            st_d = ST_ESTOP;
          end else if (rstart_q) begin
            st_d     = ST_GAP;
            gap_load = 1'b1;
          end else begin
            st_d = ST_NSTOP;
          end
        end
      end
      ST_NSTOP: if (eng_done) begin
        st_d     = ST_GAP;
        gap_load = 1'b1;
      end
      ST_GAP: if (gap_expired) st_d = ST_START;
      ST_FSTOP: if (eng_done) begin
        st_d    = ST_IDLE;
        set_rdy = 1'b1;
      end
      ST_ESTOP: if (eng_done) begin
        st_d   = ST_IDLE;
        set_to = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hold_q   <= 1'b0;
      rstart_q <= 1'b0;
    end else if (cap_en) begin
      addr_q   <= dev_addr;
      hold_q   <= hold_bus;
      rstart_q <= nack_rstart;
    end
  end

  always_comb begin
    rdy_en = cap_en | set_rdy;
    to_en  = cap_en | set_to;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdy_q <= 1'b0;
    else if (rdy_en) rdy_q <= set_rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     to_q <= 1'b0;
    else if (to_en) to_q <= set_to;
  end

  always_comb begin
    gap_run = (st_q == ST_GAP);
    eng_req = 1'b1;
    eng_op  = OP_STOP;
    unique case (st_q)
      ST_START: eng_op = OP_START;
      ST_ADDR:  eng_op = OP_SEND;
      ST_NSTOP, ST_FSTOP, ST_ESTOP: eng_op = OP_STOP;
      default:  eng_req = 1'b0;
    endcase
    eng_byte    = {addr_q, 1'b0};
    ready       = rdy_q;
    timeout_err = to_q;
  end
endmodule

// File: rtl/ackpoll_ctrl.sv
module ackpoll_ctrl
  import ackpoll_pkg::*;
#(
  parameter int MAX_TRIES = 64,
  parameter int GAP_CYC   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic [6:0] dev_addr,
  input  logic       hold_bus,
  input  logic       nack_rstart,
  output logic       eng_req,
  output logic [1:0] eng_op,
  output logic [7:0] eng_byte,
  input  logic       eng_done,
  input  logic       eng_ack,
  output logic       ready,
  output logic       timeout_err
);
  logic    rst_meta, rst_s;
  logic    try_clr, try_inc, try_last;
  logic    gap_load, gap_run, gap_expired;
  eng_op_e op_e;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  ackpoll_try_cnt #(.MAX_TRIES(MAX_TRIES)) u_try (
    .clk (clk), .rst_n(rst_s), .clr(try_clr), .inc(try_inc), .last(try_last)
  );

  ackpoll_gap_tmr #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk (clk), .rst_n(rst_s), .load(gap_load), .run(gap_run), .expired(gap_expired)
  );

  ackpoll_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .trig       (trig),
    .dev_addr   (dev_addr),
    .hold_bus   (hold_bus),
    .nack_rstart(nack_rstart),
    .eng_done   (eng_done),
    .eng_ack    (eng_ack),
    .try_last   (try_last),
    .gap_expired(gap_expired),
    .try_clr    (try_clr),
    .try_inc    (try_inc),
    .gap_load   (gap_load),
    .gap_run    (gap_run),
    .eng_req    (eng_req),
    .eng_op     (op_e),
    .eng_byte   (eng_byte),
    .ready      (ready),
    .timeout_err(timeout_err)
  );

  assign eng_op = op_e;
endmodule

// File: rtl/ackpoll_chk.sv
module ackpoll_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig,
  input logic [6:0] dev_addr,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic [7:0] eng_byte,
  input logic       eng_done,
  input logic       eng_ack,
  input logic       ready,
  input logic       timeout_err
);
  // R10: request and its payload hold until completion
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

  // R10: quiet bus interface while a result is presented
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ready || timeout_err) |-> !eng_req);

  // R8: the two results exclude each other
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && timeout_err));

  // R8: an accepted trigger clears the result flags
  a_r8_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && (ready || timeout_err)) |=> (!ready && !timeout_err));

  // R2: address byte carries the device address and write direction
  a_r2_addr_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_op == 2'd1) |-> (eng_byte == {dev_addr, 1'b0}));

  // R5: ready rises only right after an engine completion
  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(eng_done && (eng_ack || eng_op == 2'd2)));

  // R7: timeout rises only right after a completed stop
  a_r7_to_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(eng_done && eng_op == 2'd2));
endmodule

bind ackpoll_ctrl ackpoll_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .trig       (trig),
  .dev_addr   (dev_addr),
  .eng_req    (eng_req),
  .eng_op     (eng_op),
  .eng_byte   (eng_byte),
  .eng_done   (eng_done),
  .eng_ack    (eng_ack),
  .ready      (ready),
  .timeout_err(timeout_err)
);

// File: tb/ackpoll_ctrl_test.sv
`timescale 1ns/1ps
module ackpoll_ctrl_test;
  localparam int MAXT = 6;
  localparam int GAP  = 4;
  localparam int LAT  = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trig;
  logic [6:0] dev_addr;
  logic       hold_bus, nack_rstart;
  logic       eng_req;
  logic [1:0] eng_op;
  logic [7:0] eng_byte;
  logic       eng_done, eng_ack;
  logic       ready, timeout_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // responder state
  int n_start, n_stop, nack_left, lat, last_done, gap_bad, byte_bad;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ackpoll_ctrl #(.MAX_TRIES(MAXT), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .dev_addr(dev_addr),
    .hold_bus(hold_bus), .nack_rstart(nack_rstart),
    .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_ack(eng_ack),
    .ready(ready), .timeout_err(timeout_err)
  );

  // byte-engine stand-in: completes each request LAT cycles after it appears
  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; eng_ack = 1'b0; lat = 0;
    end else if (eng_done) begin
      eng_done = 1'b0; eng_ack = 1'b0; lat = 0;
    end else if (eng_req) begin
      if (lat == 0) begin
        if (eng_op == 2'd0) begin
          n_start++;
          if (n_start > 1 && (cyc - last_done) != GAP + 1) gap_bad++;
        end
        if (eng_op == 2'd2) n_stop++;
        if (eng_op == 2'd1 && eng_byte != {dev_addr, 1'b0}) byte_bad++;
      end
      lat++;
      if (lat == LAT) begin
        eng_done  = 1'b1;
        last_done = cyc;
        if (eng_op == 2'd1) begin
          if (nack_left > 0) begin eng_ack = 1'b0; nack_left--; end
          else eng_ack = 1'b1;
        end
      end
    end
  end

  function automatic int exp_starts(int n);
    return (n >= MAXT) ? MAXT : n + 1;
  endfunction

  function automatic int exp_stops(int n, bit hold, bit rs);
    if (n >= MAXT) return (rs ? 0 : MAXT - 1) + 1;
    return (rs ? 0 : n) + (hold ? 0 : 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_trial(int nacks, bit hold, bit rs, logic [6:0] addr, bit poke);
    int waited;
    bit to_exp;
    n_start = 0; n_stop = 0; gap_bad = 0; byte_bad = 0; nack_left = nacks;
    @(negedge clk);
    dev_addr = addr; hold_bus = hold; nack_rstart = rs; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(!ready && !timeout_err, "R8 trigger clears flags", {30'd0, ready, timeout_err}, 0);
    hold_bus = ~hold; nack_rstart = ~rs;  // captured values must rule
    if (poke) begin
      repeat (4) @(negedge clk);
      if (!ready && !timeout_err) begin
        trig = 1'b1; @(negedge clk); trig = 1'b0;
      end
    end
    waited = 0;
    while (!ready && !timeout_err && waited < 3000) begin
      @(negedge clk); waited++;
    end
    repeat (GAP + 3 * LAT + 4) @(negedge clk);
    to_exp = (nacks >= MAXT);
    check(n_start == exp_starts(nacks), poke ? "R9 starts with busy trigger" :
          (nacks == MAXT - 1 ? "R6 starts on last attempt" : "R3 start count"),
          n_start, exp_starts(nacks));
    check(n_stop == exp_stops(nacks, hold, rs), to_exp ? "R7 stop count" :
          (hold ? "R5 open-bus stop count" : "R3 R5 stop count"),
          n_stop, exp_stops(nacks, hold, rs));
    check(ready == !to_exp, to_exp ? "R7 ready low" : "R5 R6 ready held (R8)",
          int'(ready), int'(!to_exp));
    check(timeout_err == to_exp, "R7 timeout flag", int'(timeout_err), int'(to_exp));
    check(gap_bad == 0, "R4 attempt spacing", gap_bad, 0);
    check(byte_bad == 0, "R2 address byte", byte_bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; trig = 1'b0; dev_addr = 7'h50; hold_bus = 1'b0; nack_rstart = 1'b0;
    n_start = 0; n_stop = 0; nack_left = 0; lat = 0; last_done = 0; gap_bad = 0; byte_bad = 0;
    repeat (3) @(negedge clk);
    check(!ready && !timeout_err && !eng_req, "R1 reset outputs",
          {29'd0, ready, timeout_err, eng_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!ready && !timeout_err && !eng_req, "R1 after release",
          {29'd0, ready, timeout_err, eng_req}, 0);

    // directed corners
    run_trial(0, 1'b0, 1'b0, 7'h50, 1'b0);         // R2 R5 immediate ack
    run_trial(0, 1'b1, 1'b0, 7'h2A, 1'b0);         // R5 open bus
    run_trial(3, 1'b0, 1'b0, 7'h51, 1'b0);         // R3 stop between attempts
    run_trial(3, 1'b1, 1'b1, 7'h7F, 1'b0);         // R3 repeated start
    run_trial(MAXT - 1, 1'b0, 1'b0, 7'h00, 1'b0);  // R6 ack on final attempt
    run_trial(MAXT - 1, 1'b1, 1'b1, 7'h33, 1'b0);  // R6
    run_trial(MAXT, 1'b0, 1'b0, 7'h44, 1'b0);      // R7
    run_trial(MAXT, 1'b1, 1'b1, 7'h45, 1'b0);      // R7
    run_trial(MAXT + 3, 1'b0, 1'b1, 7'h46, 1'b0);  // R7 responder never acks in time
    run_trial(2, 1'b0, 1'b0, 7'h12, 1'b1);         // R9 trigger while busy

    // constrained random
    for (int i = 0; i < 40; i++) begin
      run_trial(int'($urandom_range(MAXT + 2, 0)), 1'($urandom_range(1, 0)),
                1'($urandom_range(1, 0)), 7'($urandom), 1'($urandom_range(1, 0)));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule